// File: doc/BRIEF.md
# Cascadable delay-select latch controller

This block is the digital control side of a programmable delay stage. An eight-bit word comes in on a data bus. Seven bits pick a delay and one bit controls cascading. The word is captured in holding registers that follow the bus while the hold input is low and freeze while it is high. Two asynchronous override inputs act on the captured word. One forces the stage to its shortest delay. The other forces it to its longest delay, using a fixed pattern in which the two fractional bits are cleared and the five integer bits are set.

The block reports the chosen delay as a count of quarter-gate units. The two lowest code bits are worth a quarter and a half of a gate delay. The next five bits are binary weighted from one gate to sixteen gates. While force-maximum is applied, one extra whole gate is added, so the stage reaches exactly 32 gates and the delay never decreases when the range spills into the next stage.

The captured cascade bit is driven out as a complementary pair. Several stages can be chained on a shared bus with one extra bus line per stage. In a chain, each stage's true cascade output drives its own force-maximum input, and its complement output drives the next stage's force-minimum input.

Top module: `dly_ctrl`

## Requirements
- R1: While hold_i is low and no override is applied, sel_o takes the value of data_i sampled at the previous rising clock edge.
- R2: While hold_i is high and no override is applied, sel_o keeps its value across clock edges whatever data_i does.
- R3: force_min_i clears all eight bits of sel_o at once, without waiting for a clock edge, regardless of hold_i and data_i.
- R4: force_max_i with force_min_i low sets sel_o[6:0] to 7'b1111100 (bits 0 and 1 low, bits 2 to 6 high) at once. sel_o[7] is not affected and keeps following the hold rule.
- R5: With force_max_i low, delay_o equals the binary value of sel_o[6:0] (bit i has weight 2^i quarter-gates), which is in the range 0 to 127.
- R6: With force_max_i high and force_min_i low, delay_o is 128, which is the 124 of the forced pattern plus one gate of 4 quarters.
- R7: casc_o equals sel_o[7] and casc_no is always its complement.
- R8: When force_min_i and force_max_i are both high, force-minimum wins: sel_o is 0 and delay_o is 0.
- R9: delay_vld_o equals in_en_i and is low whenever in_en_i is low.
- R10: When an override is removed while hold_i is high, sel_o keeps the forced value until hold_i goes low.
- R11: Two stages can be chained on a shared bus. The first stage's casc_o drives its own force_max_i and its casc_no drives the second stage's force_min_i. Then a low bus bit 7 gives the first stage its code and holds the second at 0, and a high bit 7 gives the first stage 128 and the second stage its code.
- R12: After rst_ni goes low, sel_o is 0, casc_o is 0, casc_no is 1 and delay_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock of the select registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Delay code in bits 6:0, cascade request in bit 7 |
| hold_i | input | 1 | High freezes the select word, low makes it follow data_i |
| force_min_i | input | 1 | Asynchronous force to minimum delay (clears every bit) |
| force_max_i | input | 1 | Asynchronous force to maximum delay pattern |
| in_en_i | input | 1 | Input enable that qualifies the delay report |
| sel_o | output | 8 | Captured select word |
| casc_o | output | 1 | Cascade output, true |
| casc_no | output | 1 | Cascade output, complement |
| delay_o | output | 8 | Delay in quarter-gate units |
| delay_vld_o | output | 1 | Delay report valid |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two overrides: the bench raises force-maximum and then, while it is still high, raises force-minimum. The select word and delay must then read zero, and once force-minimum drops they must return to the forced maximum pattern and 128. The second pair is a clock edge and force-maximum: with force-maximum held, a new word is clocked in. Bits 0 to 6 must keep the forced pattern while bit 7 and the cascade pair take the new value. In the chained pair the same overlap arises by itself, because the edge that captures bit 7 also releases the second stage's force-minimum. The second stage's code is judged only after one further edge.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int unsigned CODE_W    = 7;
  localparam int unsigned FINE_BITS = 2;
  localparam int unsigned SEL_W     = CODE_W + 1;
  localparam int unsigned DLY_W     = CODE_W + 1;
endpackage

// File: rtl/dly_latch_bit.sv
module dly_latch_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic hold_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i or posedge set_i) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (clr_i)   q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/dly_sel_bank.sv
module dly_sel_bank #(
  parameter int unsigned CODE_W    = dly_pkg::CODE_W,
  parameter int unsigned FINE_BITS = dly_pkg::FINE_BITS,
  localparam int unsigned SEL_W    = CODE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] data_i,
  input  logic             hold_i,
  input  logic             force_min_i,
  input  logic             force_max_i,
  output logic [SEL_W-1:0] sel_o
);
  logic max_eff;
  logic fine_clr;
  assign max_eff  = force_max_i & ~force_min_i;
  assign fine_clr = force_min_i | force_max_i;

  for (genvar i = 0; i < SEL_W; i++) begin : g_bit
    if (i < FINE_BITS) begin : g_fine
      // fractional bits: cleared by either override
      dly_latch_bit u_bit (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fine_clr), .set_i(1'b0),
        .hold_i(hold_i), .d_i(data_i[i]), .q_o(sel_o[i]));
    end else if (i < CODE_W) begin : g_whole
      dly_latch_bit u_bit (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(force_min_i), .set_i(max_eff),
        .hold_i(hold_i), .d_i(data_i[i]), .q_o(sel_o[i]));
    end else begin : g_casc
      // cascade bit: untouched by force-max, else the chain would loop
      dly_latch_bit u_bit (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(force_min_i), .set_i(1'b0),
        .hold_i(hold_i), .d_i(data_i[i]), .q_o(sel_o[i]));
    end
  end

  localparam logic [CODE_W-1:0] MAX_PAT = {{(CODE_W-FINE_BITS){1'b1}}, {FINE_BITS{1'b0}}};

  a_r3_min_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_min_i |-> (sel_o == '0));
  a_r4_max_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_max_i && !force_min_i) |-> (sel_o[CODE_W-1:0] == MAX_PAT));
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !force_min_i && !force_max_i) |=> (force_min_i || force_max_i || $stable(sel_o)));
  a_r1_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !force_min_i && !force_max_i) |=> (force_min_i || force_max_i || sel_o == $past(data_i)));
endmodule

// File: rtl/dly_weight.sv
module dly_weight #(
  parameter int unsigned CODE_W    = dly_pkg::CODE_W,
  parameter int unsigned FINE_BITS = dly_pkg::FINE_BITS,
  localparam int unsigned DLY_W    = CODE_W + 1,
  localparam int unsigned UNIT_Q   = 1 << FINE_BITS
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              top_i,
  output logic [DLY_W-1:0]  delay_o
);
  always_comb begin
    delay_o = '0;
    for (int i = 0; i < CODE_W; i++)
      if (code_i[i]) delay_o = delay_o + DLY_W'(1 << i);
    if (top_i) delay_o = delay_o + DLY_W'(UNIT_Q);
  end
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl #(
  parameter int unsigned CODE_W    = dly_pkg::CODE_W,
  parameter int unsigned FINE_BITS = dly_pkg::FINE_BITS,
  localparam int unsigned SEL_W    = CODE_W + 1,
  localparam int unsigned DLY_W    = CODE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] data_i,
  input  logic             hold_i,
  input  logic             force_min_i,
  input  logic             force_max_i,
  input  logic             in_en_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             casc_o,
  output logic             casc_no,
  output logic [DLY_W-1:0] delay_o,
  output logic             delay_vld_o
);
  logic [SEL_W-1:0] sel_q;
  logic             top_add;

  dly_sel_bank #(.CODE_W(CODE_W), .FINE_BITS(FINE_BITS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .hold_i(hold_i),
    .force_min_i(force_min_i), .force_max_i(force_max_i), .sel_o(sel_q));

  // extra gate keeps the delay monotonic across a stage boundary
  assign top_add = force_max_i & ~force_min_i;

  dly_weight #(.CODE_W(CODE_W), .FINE_BITS(FINE_BITS)) u_weight (
    .code_i(sel_q[CODE_W-1:0]), .top_i(top_add), .delay_o(delay_o));

  assign sel_o       = sel_q;
  assign casc_o      = sel_q[SEL_W-1];
  assign casc_no     = ~sel_q[SEL_W-1];
  assign delay_vld_o = in_en_i;

  a_r7_casc_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_o != casc_no);
  a_r6_top_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_max_i && !force_min_i) |-> (delay_o == DLY_W'(1 << CODE_W)));
  a_r5_delay_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_max_i |-> (delay_o < DLY_W'(1 << CODE_W)));
  a_r8_min_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_min_i && force_max_i) |-> (delay_o == '0));
endmodule

// File: tb/dly_ctrl_bench.sv
module dly_ctrl_bench;
  localparam int CLK_P = 10;

  typedef struct {
    logic [7:0] sel;
    logic [7:0] dly;
    logic       vld;
    logic       chain;
    logic [7:0] dly2;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       hold = 1'b0, fmin = 1'b0, fmax = 1'b0, en = 1'b0;
  logic [7:0] sel, dly;
  logic       casc, casc_n, vld;

  logic [7:0] bus = '0;
  logic [7:0] s1, s2, d1, d2;
  logic       c1, c1n, c2, c2n, v1, v2;

  int   checks = 0, errors = 0;
  exp_t q[$];
  event chk_ev;

  always #(CLK_P/2) clk = ~clk;

  dly_ctrl u_dly_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .hold_i(hold),
    .force_min_i(fmin), .force_max_i(fmax), .in_en_i(en),
    .sel_o(sel), .casc_o(casc), .casc_no(casc_n), .delay_o(dly), .delay_vld_o(vld));

  // R11 chain: stage one spills into stage two
  dly_ctrl u_stage1 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(bus), .hold_i(1'b0),
    .force_min_i(1'b0), .force_max_i(c1), .in_en_i(1'b1),
    .sel_o(s1), .casc_o(c1), .casc_no(c1n), .delay_o(d1), .delay_vld_o(v1));
  dly_ctrl u_stage2 (
    .clk_i(clk), .rst_ni(rst_n), .data_i({1'b0, bus[6:0]}), .hold_i(1'b0),
    .force_min_i(c1n), .force_max_i(1'b0), .in_en_i(1'b1),
    .sel_o(s2), .casc_o(c2), .casc_no(c2n), .delay_o(d2), .delay_vld_o(v2));

  task automatic push(input logic [7:0] e_sel, input logic [7:0] e_dly,
                      input logic e_vld, input string req);
    exp_t e;
    e.sel = e_sel; e.dly = e_dly; e.vld = e_vld; e.chain = 1'b0; e.dly2 = '0; e.req = req;
    q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic push_chain(input logic [7:0] e_d1, input logic [7:0] e_d2, input string req);
    exp_t e;
    e.sel = '0; e.dly = e_d1; e.vld = 1'b1; e.chain = 1'b1; e.dly2 = e_d2; e.req = req;
    q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic clk_to_sample(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic drive(input logic [7:0] d, input logic h, input logic e);
    @(negedge clk);
    data = d; hold = h; en = e;
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.chain) begin
          if (d1 !== e.dly || d2 !== e.dly2) begin
            errors++;
            $display("FAIL %s chain delays act=%0d,%0d exp=%0d,%0d", e.req, d1, d2, e.dly, e.dly2);
          end
        end else if (sel !== e.sel || dly !== e.dly || vld !== e.vld ||
                     casc !== e.sel[7] || casc_n !== ~e.sel[7]) begin
          errors++;
          $display("FAIL %s act sel=%h dly=%0d vld=%b casc=%b/%b exp sel=%h dly=%0d vld=%b casc=%b/%b",
                   e.req, sel, dly, vld, casc, casc_n, e.sel, e.dly, e.vld, e.sel[7], ~e.sel[7]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 2);
    push(8'h00, 8'd0, 1'b0, "R12 reset");
    if (c1n !== 1'b1) begin errors++; $display("FAIL R12 casc_no act=%b exp=1", c1n); end
    checks++;
    rst_n = 1'b1;

    drive(8'h2A, 1'b0, 1'b0); clk_to_sample(1);
    push(8'h2A, 8'd42, 1'b0, "R1 follow");
    drive(8'h7F, 1'b0, 1'b1); clk_to_sample(1);
    push(8'h7F, 8'd127, 1'b1, "R5 top code");
    drive(8'h85, 1'b0, 1'b1); clk_to_sample(1);
    push(8'h85, 8'd5, 1'b1, "R7 cascade high");
    drive(8'h11, 1'b1, 1'b0); clk_to_sample(2);
    push(8'h85, 8'd5, 1'b0, "R2 hold");
    push(8'h85, 8'd5, 1'b0, "R9 enable low");

    // R4/R6 asynchronous force-max while holding
    #2 fmax = 1'b1; #1;
    push(8'hFC, 8'd128, 1'b0, "R4 force max async");
    drive(8'h03, 1'b0, 1'b1); clk_to_sample(1);
    push(8'h7C, 8'd128, 1'b1, "R6 force max bit7 follows");
    // R8: both overrides together
    #1 fmin = 1'b1; #1;
    push(8'h00, 8'd0, 1'b1, "R8 min wins");
    #1 fmin = 1'b0; #1;
    push(8'h7C, 8'd128, 1'b1, "R8 max after min released");
    drive(8'h55, 1'b1, 1'b1); clk_to_sample(1);
    #1 fmax = 1'b0; #1;
    push(8'h7C, 8'd124, 1'b1, "R10 keep forced after release");
    clk_to_sample(1);
    push(8'h7C, 8'd124, 1'b1, "R10 keep after edge");

    // R3 force-min async
    #1 fmin = 1'b1; #1;
    push(8'h00, 8'd0, 1'b1, "R3 force min async");
    drive(8'hC0, 1'b0, 1'b1); clk_to_sample(1);
    push(8'h00, 8'd0, 1'b1, "R3 overrides data");
    #1 fmin = 1'b0;
    clk_to_sample(1);
    push(8'hC0, 8'd64, 1'b1, "R1 after min released");

    // R11 chain
    @(negedge clk); bus = 8'h55;
    clk_to_sample(2);
    push_chain(8'd85, 8'd0, "R11 low range");
    @(negedge clk); bus = 8'hB0;
    clk_to_sample(2);
    push_chain(8'd128, 8'd48, "R11 spill");
    @(negedge clk); bus = 8'h7F;
    clk_to_sample(2);
    push_chain(8'd127, 8'd0, "R11 back to low");

    #(CLK_P);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule